// File: doc/BRIEF.md
# Streaming Histogram Equalizer

This block equalizes the histogram of a 12-bit monochrome image that arrives as a stream, one beat per clock. A valid/ready handshake governs both sides. Each beat is a pixel, a line-end marker or a frame-end marker. While a frame arrives, the block stores every beat in an internal frame buffer. It also counts, in a 4096-bin histogram, the pixels whose value falls inside a programmable window, the counting window.

When the frame-end marker is accepted, the block walks the bins in order and turns the counts into a running total, the cumulative distribution. It then replays the stored frame through a pipelined divider. Each counted pixel is stretched onto a separate programmable target range, and pixels outside the counting window are clamped to the ends of that range. The markers come out in their original places, so a downstream consumer sees a frame with the same geometry. After replay the bins are cleared and the next frame is taken. A frame of H lines of W pixels therefore takes H*(W+1)+1 input beats, including the markers. Once replay is under way the output sustains one beat per clock.

Top module: `histEqualizer`

## Requirements
- R1: Beat kinds are coded on two bits: 0 is a pixel, 1 is a line end, 2 is a frame end. Every beat accepted in a frame is emitted once, in arrival order, with the same kind. Marker beats carry pixel value 0.
- R2: A pixel p with cntLo <= p <= cntHi is counted. Its output is tgtLo + floor((C(p) - Cmin) * S / (N - Cmin)). Here C(p) is the number of counted pixels of the frame with value <= p. N is the total number of counted pixels. Cmin is the smallest non-zero C. S is tgtHi - tgtLo when tgtHi > tgtLo, and 0 otherwise.
- R3: A pixel below cntLo is emitted as tgtLo, and a pixel above cntHi is emitted as tgtHi.
- R4: When N equals Cmin (all counted pixels share one value), every counted pixel is emitted as tgtLo.
- R5: Any output value above 4095 is emitted as 4095.
- R6: inReady is low while the bins are cleared after reset, then high until a frame end is accepted. It is low from the next cycle until that frame has been fully replayed.
- R7: While outValid is high and outReady is low, outValid, outKind and outPixel keep their values in the next cycle.
- R8: With outReady held high, replay emits a beat on every cycle from the first beat of a frame to its frame end.
- R9: Each frame is equalized from its own histogram only; counts from an earlier frame do not affect it.
- R10: During and right after reset, outValid and inReady are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| cntLo | input | 13 | Lower bound of the counting window |
| cntHi | input | 13 | Upper bound of the counting window |
| tgtLo | input | 13 | Lower bound of the target range |
| tgtHi | input | 13 | Upper bound of the target range |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Block accepts an input beat |
| inKind | input | 2 | Input beat kind (0 pixel, 1 line end, 2 frame end) |
| inPixel | input | 12 | Input pixel value |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Downstream accepts the output beat |
| outKind | output | 2 | Output beat kind, same coding as inKind |
| outPixel | output | 12 | Equalized pixel value, 0 for markers |

## Verification
The hardest cases to reach from the ports are the degenerate divisor (N equal to Cmin) and saturation of the top bin. The first needs a frame in which every counted pixel shares one value. The second needs a target range reaching 4096 together with a pixel that holds the largest cumulative count. The bench feeds full 70x70 frames from a row table: random images with a wide window and with a narrow one, a constant image, a full-range saturating setup, and a ramp. A reference model in the bench computes the expected output of every beat. Random stalls on both sides exercise the hold behaviour, and the ramp row keeps both sides always ready so that gaps in replay become visible.

// File: rtl/histEqPkg.sv
package histEqPkg;

  typedef enum logic [1:0] {
    KIND_PIXEL = 2'd0,
    KIND_EOL   = 2'd1,
    KIND_EOI   = 2'd2,
    KIND_RSVD  = 2'd3
  } beatKind_e;

  typedef enum logic [1:0] {
    CLS_IN   = 2'd0,
    CLS_LOW  = 2'd1,
    CLS_HIGH = 2'd2,
    CLS_MARK = 2'd3
  } pixClass_e;

  typedef enum logic [1:0] {
    ST_CLEAR,
    ST_ACCEPT,
    ST_SCAN,
    ST_REPLAY
  } eqState_e;

  typedef struct packed {
    logic clearBin;
    logic frameInit;
    logic acceptEn;
    logic scanBin;
    logic replayEn;
  } eqStrobe_t;

endpackage

// File: rtl/histEqControl.sv
module histEqControl
  import histEqPkg::*;
#(
  parameter int unsigned BIN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eoiTaken,
  input  logic             replayIdle,
  output eqStrobe_t        strobe,
  output logic [BIN_W-1:0] binIdx
);

  localparam logic [BIN_W-1:0] LAST_BIN = {BIN_W{1'b1}};

  eqState_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_CLEAR;
      binIdx <= '0;
    end else begin
      unique case (state)
        ST_CLEAR: begin
          binIdx <= binIdx + 1'b1;
          if (binIdx == LAST_BIN) state <= ST_ACCEPT;
        end
        ST_ACCEPT: begin
          binIdx <= '0;
          if (eoiTaken) state <= ST_SCAN;
        end
        ST_SCAN: begin
          binIdx <= binIdx + 1'b1;
          if (binIdx == LAST_BIN) state <= ST_REPLAY;
        end
        ST_REPLAY: begin
          binIdx <= '0;
          if (replayIdle) state <= ST_CLEAR;
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.clearBin  = (state == ST_CLEAR);
    strobe.frameInit = (state == ST_CLEAR);
    strobe.acceptEn  = (state == ST_ACCEPT);
    strobe.scanBin   = (state == ST_SCAN);
    strobe.replayEn  = (state == ST_REPLAY);
  end

endmodule

// File: rtl/histEqDatapath.sv
module histEqDatapath
  import histEqPkg::*;
#(
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned FB_DEPTH = 5120
) (
  input  logic             clk,
  input  logic             rstN,
  input  eqStrobe_t        strobe,
  input  logic [PIX_W-1:0] binIdx,
  input  logic [PIX_W:0]   cntLo,
  input  logic [PIX_W:0]   cntHi,
  input  logic [PIX_W:0]   tgtLo,
  input  logic [PIX_W:0]   tgtHi,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       inKind,
  input  logic [PIX_W-1:0] inPixel,
  output logic             eoiTaken,
  output logic             replayIdle,
  output logic             outValid,
  input  logic             outReady,
  output logic [1:0]       outKind,
  output logic [PIX_W-1:0] outPixel
);

  localparam int unsigned NBINS  = 1 << PIX_W;
  localparam int unsigned RNG_W  = PIX_W + 1;
  localparam int unsigned QW     = RNG_W;
  localparam int unsigned CNT_W  = $clog2(FB_DEPTH + 1);
  localparam int unsigned FB_AW  = $clog2(FB_DEPTH);
  localparam int unsigned NUM_W  = CNT_W + RNG_W;
  localparam int unsigned DW     = NUM_W + QW;
  localparam int unsigned BEAT_W = 2 + PIX_W;
  localparam logic [RNG_W:0]   PIX_MAX  = (RNG_W + 1)'(NBINS - 1);
  localparam logic [CNT_W-1:0] FB_LIMIT = CNT_W'(FB_DEPTH);

  // storage
  logic [CNT_W-1:0]  hist     [NBINS];
  logic [BEAT_W-1:0] frameBuf [FB_DEPTH];

  // accept side
  logic             take;
  logic             inCounted;
  logic             hVld;
  logic [PIX_W-1:0] hBin;
  logic [CNT_W-1:0] wrCount;

  // cumulative statistics
  logic [CNT_W-1:0] runSum;
  logic [CNT_W-1:0] cdfMin;
  logic             minFound;
  logic [CNT_W-1:0] scanSum;
  logic [CNT_W-1:0] den;
  logic             denZero;

  assign take      = inValid && strobe.acceptEn;
  assign inReady   = strobe.acceptEn;
  assign eoiTaken  = take && (inKind == KIND_EOI);
  assign inCounted = ({1'b0, inPixel} >= cntLo) && ({1'b0, inPixel} <= cntHi);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCount <= '0;
      hVld    <= 1'b0;
      hBin    <= '0;
    end else begin
      hVld <= take && (inKind == KIND_PIXEL) && inCounted && (wrCount < FB_LIMIT);
      hBin <= inPixel;
      if (strobe.frameInit) wrCount <= '0;
      else if (take && (wrCount < FB_LIMIT)) wrCount <= wrCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && (wrCount < FB_LIMIT)) frameBuf[wrCount[FB_AW-1:0]] <= {inKind, inPixel};
  end

  // single write port: clear, prefix-sum rewrite, or increment
  assign scanSum = runSum + hist[binIdx];

  always_ff @(posedge clk) begin
    if (strobe.clearBin)     hist[binIdx] <= '0;
    else if (strobe.scanBin) hist[binIdx] <= scanSum;
    else if (hVld)           hist[hBin]   <= hist[hBin] + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runSum   <= '0;
      cdfMin   <= '0;
      minFound <= 1'b0;
    end else if (strobe.frameInit) begin
      runSum   <= '0;
      cdfMin   <= '0;
      minFound <= 1'b0;
    end else if (strobe.scanBin) begin
      runSum <= scanSum;
      if (!minFound && (hist[binIdx] != '0)) begin
        cdfMin   <= scanSum;
        minFound <= 1'b1;
      end
    end
  end

  assign den     = runSum - cdfMin;
  assign denZero = (den == '0);

  // replay pipeline
  logic                adv;
  logic                issue;
  logic                aV;
  logic [CNT_W-1:0]    rdPtr;
  logic [BEAT_W-1:0]   fbQ;
  logic [PIX_W-1:0]    fbPix;
  logic [1:0]          fbKind;
  pixClass_e           fbCls;
  logic                bV;
  logic [1:0]          bKind;
  pixClass_e           bCls;
  logic [CNT_W-1:0]    cdfQ;
  logic [RNG_W-1:0]    span;
  logic [NUM_W-1:0]    product;
  logic [QW:0]         dV;
  logic [1:0]          dKind [QW+1];
  pixClass_e           dCls  [QW+1];
  logic [QW-1:0]       dQ    [QW+1];
  logic [NUM_W-1:0]    dRem  [QW];
  logic [NUM_W-1:0]    remNext [QW];
  logic [QW-1:0]       qNext   [QW];
  logic [RNG_W:0]      mapped;
  logic [PIX_W-1:0]    finalPix;
  logic                outValidQ;
  logic [1:0]          outKindQ;
  logic [PIX_W-1:0]    outPixQ;

  assign adv   = !outValidQ || outReady;
  assign issue = strobe.replayEn && (rdPtr != wrCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aV    <= 1'b0;
      rdPtr <= '0;
    end else if (strobe.frameInit) begin
      aV    <= 1'b0;
      rdPtr <= '0;
    end else if (adv) begin
      aV <= issue;
      if (issue) rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && issue) fbQ <= frameBuf[rdPtr[FB_AW-1:0]];
  end

  assign fbPix  = fbQ[PIX_W-1:0];
  assign fbKind = fbQ[BEAT_W-1 -: 2];

  always_comb begin
    if (fbKind != KIND_PIXEL)            fbCls = CLS_MARK;
    else if ({1'b0, fbPix} < cntLo)      fbCls = CLS_LOW;
    else if ({1'b0, fbPix} > cntHi)      fbCls = CLS_HIGH;
    else                                 fbCls = CLS_IN;
  end

  assign span    = (tgtHi > tgtLo) ? (tgtHi - tgtLo) : '0;
  assign product = NUM_W'(cdfQ - cdfMin) * NUM_W'(span);

  // restoring divider, one quotient bit per stage
  for (genvar g = 0; g < QW; g++) begin : gDivStage
    localparam int unsigned SH = QW - 1 - g;
    logic [DW-1:0] denSh;
    logic [DW-1:0] remExt;
    logic          fits;
    assign denSh      = DW'(den) << SH;
    assign remExt     = DW'(dRem[g]);
    assign fits       = (remExt >= denSh);
    assign remNext[g] = fits ? NUM_W'(remExt - denSh) : dRem[g];
    assign qNext[g]   = fits ? (dQ[g] | (QW'(1) << SH)) : dQ[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bV        <= 1'b0;
      dV        <= '0;
      outValidQ <= 1'b0;
    end else if (adv) begin
      bV        <= aV;
      dV        <= {dV[QW-1:0], bV};
      outValidQ <= dV[QW];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      bKind    <= fbKind;
      bCls     <= fbCls;
      cdfQ     <= hist[fbPix];
      dKind[0] <= bKind;
      dCls[0]  <= bCls;
      dQ[0]    <= '0;
      dRem[0]  <= (bCls == CLS_IN) ? product : '0;
      for (int g = 0; g < QW; g++) begin
        dKind[g+1] <= dKind[g];
        dCls[g+1]  <= dCls[g];
        dQ[g+1]    <= qNext[g];
      end
      for (int g = 0; g < QW - 1; g++) dRem[g+1] <= remNext[g];
      outKindQ <= dKind[QW];
      outPixQ  <= finalPix;
    end
  end

  always_comb begin
    unique case (dCls[QW])
      CLS_LOW:  mapped = {1'b0, tgtLo};
      CLS_HIGH: mapped = {1'b0, tgtHi};
      CLS_IN:   mapped = denZero ? {1'b0, tgtLo} : ({1'b0, tgtLo} + {1'b0, dQ[QW]});
      default:  mapped = '0;
    endcase
    if (dKind[QW] != KIND_PIXEL) finalPix = '0;
    else if (mapped > PIX_MAX)   finalPix = PIX_MAX[PIX_W-1:0];
    else                         finalPix = mapped[PIX_W-1:0];
  end

  assign replayIdle = strobe.replayEn && (rdPtr == wrCount) && !aV && !bV && (dV == '0);

  assign outValid = outValidQ;
  assign outKind  = outKindQ;
  assign outPixel = outPixQ;

endmodule

// File: rtl/histEqualizer.sv
module histEqualizer
  import histEqPkg::*;
#(
  parameter int unsigned PIX_W    = 12,
  parameter int unsigned FB_DEPTH = 5120
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W:0]   cntLo,
  input  logic [PIX_W:0]   cntHi,
  input  logic [PIX_W:0]   tgtLo,
  input  logic [PIX_W:0]   tgtHi,
  input  logic             inValid,
  output logic             inReady,
  input  logic [1:0]       inKind,
  input  logic [PIX_W-1:0] inPixel,
  output logic             outValid,
  input  logic             outReady,
  output logic [1:0]       outKind,
  output logic [PIX_W-1:0] outPixel
);

  eqStrobe_t        strobe;
  logic [PIX_W-1:0] binIdx;
  logic             eoiTaken;
  logic             replayIdle;

  histEqControl #(.BIN_W(PIX_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .eoiTaken   (eoiTaken),
    .replayIdle (replayIdle),
    .strobe     (strobe),
    .binIdx     (binIdx)
  );

  histEqDatapath #(.PIX_W(PIX_W), .FB_DEPTH(FB_DEPTH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .binIdx     (binIdx),
    .cntLo      (cntLo),
    .cntHi      (cntHi),
    .tgtLo      (tgtLo),
    .tgtHi      (tgtHi),
    .inValid    (inValid),
    .inReady    (inReady),
    .inKind     (inKind),
    .inPixel    (inPixel),
    .eoiTaken   (eoiTaken),
    .replayIdle (replayIdle),
    .outValid   (outValid),
    .outReady   (outReady),
    .outKind    (outKind),
    .outPixel   (outPixel)
  );

endmodule

// File: rtl/histEqualizerChecker.sv
module histEqualizerChecker #(
  parameter int unsigned PIX_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic [PIX_W:0]   tgtLo,
  input logic [PIX_W:0]   tgtHi,
  input logic             inValid,
  input logic             inReady,
  input logic [1:0]       inKind,
  input logic             outValid,
  input logic             outReady,
  input logic [1:0]       outKind,
  input logic [PIX_W-1:0] outPixel
);

  localparam logic [PIX_W:0] PIX_TOP = {1'b0, {PIX_W{1'b1}}};

  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

  assert_hold_beat_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> ($stable(outKind) && $stable(outPixel)));

  assert_eoi_drops_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && (inKind == 2'd2)) |=> !inReady);

  assert_marker_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outKind != 2'd0)) |-> (outPixel == '0));

  assert_in_target_R2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (outKind == 2'd0) && (tgtLo <= tgtHi) && (tgtHi <= PIX_TOP))
      |-> (({1'b0, outPixel} >= tgtLo) && ({1'b0, outPixel} <= tgtHi)));

endmodule

bind histEqualizer histEqualizerChecker #(.PIX_W(PIX_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .tgtLo    (tgtLo),
  .tgtHi    (tgtHi),
  .inValid  (inValid),
  .inReady  (inReady),
  .inKind   (inKind),
  .outValid (outValid),
  .outReady (outReady),
  .outKind  (outKind),
  .outPixel (outPixel)
);

// File: tb/histEqualizer_test.sv
`timescale 1ns/1ps
module histEqualizer_test;

  localparam int PIX_W  = 12;
  localparam int NB     = 1 << PIX_W;
  localparam int PMAX   = NB - 1;
  localparam int H      = 70;
  localparam int W      = 70;
  localparam int NPIX   = H * W;
  localparam int NBEAT  = H * (W + 1) + 1;
  localparam int NROWS  = 5;
  localparam int WATCHDOG = 190000;

  // row: counting window, target range, pattern (0 random, 1 constant 777, 2 ramp), stalls
  typedef struct packed {
    logic [12:0] dLo;
    logic [12:0] dHi;
    logic [12:0] oLo;
    logic [12:0] oHi;
    logic [1:0]  pat;
    logic        bp;
  } row_t;

  localparam row_t ROWS [NROWS] = '{
    '{13'd100,  13'd3900, 13'd200,  13'd3800, 2'd0, 1'b1},
    '{13'd1000, 13'd2000, 13'd1100, 13'd1900, 2'd0, 1'b1},
    '{13'd0,    13'd4096, 13'd300,  13'd3000, 2'd1, 1'b1},
    '{13'd0,    13'd4096, 13'd0,    13'd4096, 2'd0, 1'b1},
    '{13'd50,   13'd4000, 13'd60,   13'd3990, 2'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [12:0] cntLo, cntHi, tgtLo, tgtHi;
  logic        inValid;
  logic        inReady;
  logic [1:0]  inKind;
  logic [11:0] inPixel;
  logic        outValid;
  logic        outReady;
  logic [1:0]  outKind;
  logic [11:0] outPixel;

  always #2 clk = ~clk;

  histEqualizer uut (
    .clk(clk), .rstN(rstN),
    .cntLo(cntLo), .cntHi(cntHi), .tgtLo(tgtLo), .tgtHi(tgtHi),
    .inValid(inValid), .inReady(inReady), .inKind(inKind), .inPixel(inPixel),
    .outValid(outValid), .outReady(outReady), .outKind(outKind), .outPixel(outPixel)
  );

  int checks = 0;
  int errors = 0;
  int frameErrs;

  int beatKind [NBEAT];
  int beatPix  [NBEAT];
  int expPix   [NBEAT];
  int expCls   [NBEAT]; // 0 marker, 1 mapped, 2 clamped, 3 flat, 4 saturated
  int hist     [NB];
  int cdf      [NB];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      frameErrs++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int satPix(input longint v);
    return (v > PMAX) ? PMAX : int'(v);
  endfunction

  task automatic buildFrame(input row_t row);
    int idx = 0;
    int nIn = 0;
    int cMin = 0;
    int run = 0;
    longint span;
    for (int v = 0; v < NB; v++) hist[v] = 0;
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        int p;
        if (row.pat == 2'd1)      p = 777;
        else if (row.pat == 2'd2) p = (r * W + c) % NB;
        else                      p = int'($urandom_range(PMAX));
        beatKind[idx] = 0;
        beatPix[idx]  = p;
        if (p >= int'(row.dLo) && p <= int'(row.dHi)) hist[p]++;
        idx++;
      end
      beatKind[idx] = 1; beatPix[idx] = 0; idx++;
    end
    beatKind[idx] = 2; beatPix[idx] = 0;
    for (int v = 0; v < NB; v++) begin
      run += hist[v];
      cdf[v] = run;
      if (cMin == 0 && hist[v] != 0) cMin = run;
    end
    nIn  = run;
    span = (row.oHi > row.oLo) ? longint'(row.oHi) - longint'(row.oLo) : 0;
    for (int i = 0; i < NBEAT; i++) begin
      int p = beatPix[i];
      if (beatKind[i] != 0) begin
        expPix[i] = 0; expCls[i] = 0;
      end else if (p < int'(row.dLo)) begin
        expPix[i] = satPix(row.oLo); expCls[i] = 2;
      end else if (p > int'(row.dHi)) begin
        expPix[i] = satPix(row.oHi); expCls[i] = 2;
      end else if (nIn == cMin) begin
        expPix[i] = satPix(row.oLo); expCls[i] = 3;
      end else begin
        longint raw = longint'(row.oLo) + (longint'(cdf[p] - cMin) * span) / longint'(nIn - cMin);
        expPix[i] = satPix(raw);
        expCls[i] = (raw > PMAX) ? 4 : 1;
      end
    end
  endtask

  task automatic driveFrame(input bit bp);
    for (int i = 0; i < NBEAT; i++) begin
      bit acc = 1'b0;
      while (!acc) begin
        @(negedge clk);
        inValid = bp ? ($urandom_range(4) != 0) : 1'b1;
        inKind  = 2'(beatKind[i]);
        inPixel = 12'(beatPix[i]);
        acc = inValid && inReady;
        @(posedge clk);
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R6", "inReady after frame end", int'(inReady), 0);
  endtask

  task automatic collectFrame(input bit bp);
    int idx = 0;
    int gaps = 0;
    bit started = 1'b0;
    bit held = 1'b0;
    int hKind = 0;
    int hPix = 0;
    while (idx < NBEAT) begin
      bit rdy;
      @(negedge clk);
      if (held) begin
        check(outValid == 1'b1, "R7", "valid while stalled", int'(outValid), 1);
        check(int'(outKind) == hKind && int'(outPixel) == hPix, "R7", "beat while stalled",
              int'(outPixel), hPix);
      end
      rdy = bp ? ($urandom_range(3) != 0) : 1'b1;
      outReady = rdy;
      if (outValid && rdy) begin
        string tag;
        case (expCls[idx])
          0: tag = "R1";
          1: tag = "R2";
          2: tag = "R3";
          3: tag = "R4";
          default: tag = "R5";
        endcase
        check(int'(outKind) == beatKind[idx], "R1", "beat kind", int'(outKind), beatKind[idx]);
        check(int'(outPixel) == expPix[idx], tag, "pixel value", int'(outPixel), expPix[idx]);
        if (beatKind[idx] == 2)
          check(inReady == 1'b0, "R6", "inReady during replay", int'(inReady), 0);
        idx++;
        started = 1'b1;
      end else if (started && !outValid) begin
        gaps++;
      end
      held  = outValid && !rdy;
      hKind = int'(outKind);
      hPix  = int'(outPixel);
    end
    if (!bp) check(gaps == 0, "R8", "idle cycles inside replay", gaps, 0);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected below %0d", WATCHDOG, WATCHDOG);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : mainSeq
    int waited = 0;
    rstN = 1'b0; inValid = 1'b0; inKind = 2'd0; inPixel = '0; outReady = 1'b0;
    cntLo = '0; cntHi = '0; tgtLo = '0; tgtHi = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(outValid == 1'b0, "R10", "outValid in reset", int'(outValid), 0);
    check(inReady == 1'b0, "R10", "inReady in reset", int'(inReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R10", "outValid after reset", int'(outValid), 0);
    check(inReady == 1'b0, "R10", "inReady after reset", int'(inReady), 0);
    while (!inReady && waited < 6000) begin
      @(negedge clk);
      waited++;
    end
    check(waited >= NB - 8 && waited <= NB + 8, "R6", "cycles of bin clearing", waited, NB);

    for (int r = 0; r < NROWS; r++) begin
      cntLo = ROWS[r].dLo; cntHi = ROWS[r].dHi;
      tgtLo = ROWS[r].oLo; tgtHi = ROWS[r].oHi;
      buildFrame(ROWS[r]);
      frameErrs = 0;
      fork
        driveFrame(ROWS[r].bp);
        collectFrame(ROWS[r].bp);
      join
      if (r > 0) check(frameErrs == 0, "R9", "mismatches in later frame", frameErrs, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule